// File: doc/BRIEF.md
# Indexed Register Gather Sequencer

This block moves whole registers inside a small register file, one move per clock. Each move takes its source from an index. The indices sit packed in a group of consecutive registers that starts at a chosen base register. An index can be 8, 16 or 32 bits wide, or it can fill a whole register. For each step the sequencer extracts the next index, reads register `rd + index`, and writes that value to the next destination register. Destinations run upward from `rd`.

The work is a loop of `VL` outer iterations with `SUBVL` inner iterations each. A mode bit decides where the index counter comes from. In grouped mode it restarts for every outer iteration, so every group reuses the same pattern, for example to transpose inside a group. In running mode it keeps counting across the whole loop. A start pulse together with a 4-bit function code launches the operation. A one-cycle done pulse follows the last write. A test port preloads and inspects the 32-entry register file while the sequencer is idle.

Top module: `reg_gather_seq`

## Requirements
- R1: After reset, `busy` and `done` are 0 and every register reads zero through the test port.
- R2: `start` launches an operation only when `func[0]` is 1. A start with `func[0]` at 0, including code 0000, changes no register and raises neither `busy` nor `done`.
- R3: `func[3:2]` selects the index width: 0 gives a whole register (32 bits), 1 gives 8 bits, 2 gives 16 bits, 3 gives 32 bits. The width of the moved data is always a whole register, whatever the index width.
- R4: Index k lies at byte offset k × (index bytes) in the register group that starts at `rs1`. Each register holds 4 bytes, the least significant byte first, and the group address wraps modulo 32. Only the low 5 bits of an index are used. With 8-bit indices, the value 0x00020301 yields the indices 1, 3, 2, 0.
- R5: The source of each step is register (`rd` + index) mod 32. Its whole value is copied.
- R6: The destination starts at `rd` and rises by one after every write, modulo 32. There are `VL` × `SUBVL` steps, with `SUBVL`=0 counted as 1. There is one write per cycle, and each step sees the writes of the steps before it.
- R7: With `func[1]`=1 (grouped mode), the index counter equals the inner iteration number and restarts at 0 for every outer iteration.
- R8: With `func[1]`=0 (running mode), the index counter equals the overall step number and does not restart.
- R9: Register 0 always reads zero. Writes to it from the sequencer or from the test port are dropped.
- R10: While `busy` is 1, a new `start` is ignored and test-port writes are ignored. The running operation finishes unchanged.
- R11: `done` is high for exactly one cycle. It comes in the cycle after the last write, when `busy` has already dropped. The number of busy cycles equals the step count. With `VL`=0, `done` comes in the cycle after the start and nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch pulse |
| func | input | 4 | Function code: bit 0 selects the move, bit 1 selects grouped mode, bits 3:2 select the index width |
| vl | input | 4 | Outer iteration count |
| subvl | input | 3 | Inner iteration count (0 counts as 1) |
| rd | input | 5 | Destination base register, also the base of the source offset |
| rs1 | input | 5 | First register of the index group |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| tp_we | input | 1 | Test-port write enable (ignored while busy) |
| tp_addr | input | 5 | Test-port register number |
| tp_wdata | input | 32 | Test-port write data |
| tp_rdata | output | 32 | Test-port read data (combinational) |

## Verification
The assertions check four things on every cycle. Done lasts one cycle and never overlaps busy. The latched operands hold steady for the whole run. The write address steps by exactly one between consecutive busy cycles. In grouped mode the inner counter stays below the group size. Other properties show up only in whole scenarios, because they depend on register contents built up over many steps: the right index bytes picked at each width, restart against running counting, read-after-write between steps, wrap of addresses past register 31, and dropped writes to register 0. The bench covers these by checking the full register file against a sequential model after each operation.

// File: rtl/gath_pkg.sv
// Package gath_pkg
// Shared types for the gather sequencer: the index width code and a helper
// that turns it into a byte count. Assumes registers are at least 32 bits.
package gath_pkg;

    typedef enum logic [1:0] {
        IW_FULL = 2'd0,
        IW_B8   = 2'd1,
        IW_B16  = 2'd2,
        IW_B32  = 2'd3
    } idx_width_e;

    // Bytes that one index occupies for a given code and register byte width.
    function automatic int idx_bytes(idx_width_e w, int reg_bytes);
        case (w)
            IW_B8:   return 1;
            IW_B16:  return 2;
            IW_B32:  return 4;
            default: return reg_bytes;
        endcase
    endfunction

endpackage

// File: rtl/gath_regfile.sv
// Module gath_regfile
// Behavioural register file with one write port and three combinational
// read ports. Entry 0 holds zero permanently. Assumes NREG is a power of two.
module gath_regfile #(
    parameter int XLEN = 32,
    parameter int AW   = 5,
    localparam int NREG = 1 << AW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [AW-1:0]   ra_addr,
    output logic [XLEN-1:0] ra_data,
    input  logic [AW-1:0]   rb_addr,
    output logic [XLEN-1:0] rb_data,
    input  logic [AW-1:0]   rc_addr,
    output logic [XLEN-1:0] rc_data
);

    logic [XLEN-1:0] mem [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_row
        if (g == 0) begin : g_zero
            // Row 0: constant zero, writes never land here.
            always_ff @(posedge clk) begin
                mem[g] <= '0;
            end
        end else begin : g_data
            // Row g: cleared on reset, loaded when addressed.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem[g] <= '0;
                end else if (we && waddr == AW'(g)) begin
                    mem[g] <= wdata;
                end
            end
        end
    end

    // Read ports: plain array lookups (row 0 is always zero).
    always_comb begin
        ra_data = mem[ra_addr];
        rb_data = mem[rb_addr];
        rc_data = mem[rc_addr];
    end

endmodule

// File: rtl/gath_idx_extract.sv
// Module gath_idx_extract
// Finds index k inside the packed group that starts at rs1. It produces the
// register number to read and, from that register's data, the index value
// cut to AW bits. Assumes XLEN is a multiple of 8 and at least 32.
module gath_idx_extract
    import gath_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int AW    = 5,
    parameter int CNT_W = 7,
    localparam int XB    = XLEN / 8,
    localparam int LB    = $clog2(XB),
    localparam int OFF_W = CNT_W + LB + 1
) (
    input  logic [CNT_W-1:0] k,
    input  logic [AW-1:0]    rs1,
    input  idx_width_e       wcode,
    output logic [AW-1:0]    grp_addr,
    input  logic [XLEN-1:0]  grp_data,
    output logic [AW-1:0]    idx
);

    logic [LB:0]       nbytes;
    logic [OFF_W-1:0]  off;
    logic [LB-1:0]     lane;
    logic [XLEN-1:0]   shifted;
    logic [XLEN-1:0]   mask;

    // Byte offset of index k, split into a register step and a byte lane.
    always_comb begin
        nbytes   = (LB+1)'(idx_bytes(wcode, XB));
        off      = OFF_W'(k) * OFF_W'(nbytes);
        grp_addr = rs1 + AW'(off >> LB);
        lane     = off[LB-1:0];
    end

    // Shift the addressed lane down and keep only the index's own bytes.
    always_comb begin
        shifted = grp_data >> {lane, 3'b000};
        mask    = '0;
        for (int b = 0; b < XB; b++) begin
            if (b < int'(nbytes)) mask[b*8 +: 8] = 8'hFF;
        end
        idx = AW'(shifted & mask);
    end

endmodule

// File: rtl/gath_ctrl.sv
// Module gath_ctrl
// Loop controller. It latches the operands at launch, walks VL outer by
// SUBVL inner iterations at one step per cycle, picks the index counter by
// mode and pulses done. Assumes the outer loop runs for VL in 1..2^VL_W-1.
module gath_ctrl
    import gath_pkg::*;
#(
    parameter int AW    = 5,
    parameter int VL_W  = 4,
    parameter int SUB_W = 3,
    localparam int CNT_W = VL_W + SUB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [3:0]       func,
    input  logic [VL_W-1:0]  vl,
    input  logic [SUB_W-1:0] subvl,
    input  logic [AW-1:0]    rd,
    input  logic [AW-1:0]    rs1,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] k,
    output logic [AW-1:0]    rd_base,
    output logic [AW-1:0]    rs1_base,
    output idx_width_e       wcode,
    output logic [AW-1:0]    dst
);

    logic             busy_q, done_q, grp_q;
    logic [CNT_W-1:0] step_q;
    logic [SUB_W-1:0] j_q, sub_q, sub_eff;
    logic [VL_W-1:0]  i_q, vl_q;
    logic [AW-1:0]    rd_q, rs1_q;
    idx_width_e       wc_q;
    logic             launch, last_inner, last_outer;

    // Launch decode and loop-end conditions.
    always_comb begin
        launch     = start && !busy_q && func[0];
        sub_eff    = (subvl == '0) ? SUB_W'(1) : subvl;
        last_inner = (j_q == sub_q - SUB_W'(1));
        last_outer = (i_q == vl_q - VL_W'(1));
    end

    // Operand latch and loop counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            grp_q  <= 1'b0;
            step_q <= '0;
            j_q    <= '0;
            i_q    <= '0;
            sub_q  <= SUB_W'(1);
            vl_q   <= '0;
            rd_q   <= '0;
            rs1_q  <= '0;
            wc_q   <= IW_FULL;
        end else begin
            done_q <= 1'b0;
            if (launch) begin
                grp_q  <= func[1];
                wc_q   <= idx_width_e'(func[3:2]);
                rd_q   <= rd;
                rs1_q  <= rs1;
                vl_q   <= vl;
                sub_q  <= sub_eff;
                step_q <= '0;
                j_q    <= '0;
                i_q    <= '0;
                if (vl == '0) done_q <= 1'b1;
                else          busy_q <= 1'b1;
            end else if (busy_q) begin
                step_q <= step_q + CNT_W'(1);
                if (last_inner) begin
                    j_q <= '0;
                    i_q <= i_q + VL_W'(1);
                    if (last_outer) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end
                end else begin
                    j_q <= j_q + SUB_W'(1);
                end
            end
        end
    end

    // Outputs: index counter by mode, destination from the step count.
    always_comb begin
        busy     = busy_q;
        done     = done_q;
        k        = grp_q ? CNT_W'(j_q) : step_q;
        rd_base  = rd_q;
        rs1_base = rs1_q;
        wcode    = wc_q;
        dst      = rd_q + AW'(step_q);
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);                                           // R11
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q);                                           // R11
    AST_OPERANDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> (!busy_q || ($stable(rd_q) && $stable(rs1_q) && $stable(vl_q)))); // R10
    AST_GROUP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && grp_q) |-> (j_q < sub_q));                          // R7

endmodule

// File: rtl/reg_gather_seq.sv
// Module reg_gather_seq
// Top of the indexed gather sequencer. It ties the controller, the index
// extractor and the register file together. While busy, the sequencer owns
// the write port; while idle, the test port owns it. Assumes 2^AW registers.
module reg_gather_seq
    import gath_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int AW    = 5,
    parameter int VL_W  = 4,
    parameter int SUB_W = 3,
    localparam int CNT_W = VL_W + SUB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [3:0]       func,
    input  logic [VL_W-1:0]  vl,
    input  logic [SUB_W-1:0] subvl,
    input  logic [AW-1:0]    rd,
    input  logic [AW-1:0]    rs1,
    output logic             busy,
    output logic             done,
    input  logic             tp_we,
    input  logic [AW-1:0]    tp_addr,
    input  logic [XLEN-1:0]  tp_wdata,
    output logic [XLEN-1:0]  tp_rdata
);

    logic [CNT_W-1:0] k;
    logic [AW-1:0]    rd_base, rs1_base, dst, grp_addr, idx, src_addr, waddr;
    logic [XLEN-1:0]  grp_data, src_data, wdata;
    logic             we;
    idx_width_e       wcode;

    gath_ctrl #(.AW(AW), .VL_W(VL_W), .SUB_W(SUB_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .func     (func),
        .vl       (vl),
        .subvl    (subvl),
        .rd       (rd),
        .rs1      (rs1),
        .busy     (busy),
        .done     (done),
        .k        (k),
        .rd_base  (rd_base),
        .rs1_base (rs1_base),
        .wcode    (wcode),
        .dst      (dst)
    );

    gath_idx_extract #(.XLEN(XLEN), .AW(AW), .CNT_W(CNT_W)) u_idx (
        .k        (k),
        .rs1      (rs1_base),
        .wcode    (wcode),
        .grp_addr (grp_addr),
        .grp_data (grp_data),
        .idx      (idx)
    );

    // Write-port ownership and source address.
    always_comb begin
        src_addr = rd_base + idx;
        we       = busy ? 1'b1 : tp_we;
        waddr    = busy ? dst : tp_addr;
        wdata    = busy ? src_data : tp_wdata;
    end

    gath_regfile #(.XLEN(XLEN), .AW(AW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (we),
        .waddr   (waddr),
        .wdata   (wdata),
        .ra_addr (grp_addr),
        .ra_data (grp_data),
        .rb_addr (src_addr),
        .rb_data (src_data),
        .rc_addr (tp_addr),
        .rc_data (tp_rdata)
    );

    AST_DEST_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (dst == $past(dst) + AW'(1)));       // R6

endmodule

// File: tb/reg_gather_seq_bench.sv
`timescale 1ns/1ps
module reg_gather_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  func = '0;
    logic [3:0]  vl = '0;
    logic [2:0]  subvl = '0;
    logic [4:0]  rd = '0, rs1 = '0;
    logic        busy, done;
    logic        tp_we = 1'b0;
    logic [4:0]  tp_addr = '0;
    logic [31:0] tp_wdata = '0;
    logic [31:0] tp_rdata;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [31:0] mdl [32];

    reg_gather_seq u_reg_gather_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .func(func), .vl(vl),
        .subvl(subvl), .rd(rd), .rs1(rs1), .busy(busy), .done(done),
        .tp_we(tp_we), .tp_addr(tp_addr), .tp_wdata(tp_wdata), .tp_rdata(tp_rdata)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: act cycles=%0d exp below 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tp_write(input int a, input logic [31:0] d);
        @(negedge clk);
        tp_we = 1'b1; tp_addr = 5'(a); tp_wdata = d;
        @(negedge clk);
        tp_we = 1'b0;
        if (a != 0) mdl[a] = d;
    endtask

    task automatic compare_all(input string tag);
        @(negedge clk);
        for (int r = 0; r < 32; r++) begin
            tp_addr = 5'(r);
            #0.1;
            chk(tp_rdata == mdl[r], $sformatf("%s reg x%0d", tag, r), tp_rdata, mdl[r]);
        end
    endtask

    task automatic preload();
        for (int r = 1; r < 32; r++) tp_write(r, $urandom);
    endtask

    // Expected index number k of the packed group (R3, R4).
    function automatic int model_idx(int k, int w, int base);
        int nb, off, reg_n, lane;
        logic [31:0] v;
        nb    = (w == 1) ? 1 : (w == 2) ? 2 : 4;
        off   = k * nb;
        reg_n = (base + off / 4) % 32;
        lane  = off % 4;
        v     = mdl[reg_n] >> (8 * lane);
        return int'(v[4:0]);
    endfunction

    // Sequential reference run on the model (R5..R9).
    task automatic model_run(input logic [3:0] f, input int v, input int s, input int d, input int b);
        int se, step, kk, src, dd;
        se = (s == 0) ? 1 : s;
        step = 0;
        for (int i = 0; i < v; i++) begin
            for (int j = 0; j < se; j++) begin
                kk  = f[1] ? j : step;
                src = (d + model_idx(kk, int'(f[3:2]), b)) % 32;
                dd  = (d + step) % 32;
                if (dd != 0) mdl[dd] = mdl[src];
                step++;
            end
        end
    endtask

    task automatic run_op(input logic [3:0] f, input int v, input int s, input int d,
                          input int b, input bit poke, input string tag);
        int steps, cnt;
        steps = v * ((s == 0) ? 1 : s);
        model_run(f, v, s, d, b);
        @(negedge clk);
        start = 1'b1; func = f; vl = 4'(v); subvl = 3'(s); rd = 5'(d); rs1 = 5'(b);
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        while (!done && cnt < 1000) begin
            cnt++;
            if (poke && cnt == 1) begin
                // R10: a restart and a test-port write while busy
                start = 1'b1; func = 4'b0101; rd = 5'(d + 7); rs1 = 5'(b + 3);
                tp_we = 1'b1; tp_addr = 5'(d + 1); tp_wdata = 32'hA5A5_5A5A;
            end
            @(negedge clk);
            start = 1'b0; tp_we = 1'b0;
        end
        chk(cnt == steps, {tag, " R11 busy cycles"}, cnt, steps);
        chk(busy == 1'b0, {tag, " R11 busy low at done"}, busy, 0);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R11 done one cycle"}, done, 0);
        compare_all(tag);
    endtask

    task automatic try_ignored(input logic [3:0] f);
        @(negedge clk);
        start = 1'b1; func = f; vl = 4'd3; subvl = 3'd2; rd = 5'd4; rs1 = 5'd9;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b0 && done == 1'b0, $sformatf("R2 code %b no launch", f), {busy, done}, 0);
        @(negedge clk);
        chk(done == 1'b0, "R2 no done later", done, 0);
        compare_all("R2");
    endtask

    initial begin
        logic [31:0] old4;
        void'($urandom(32'd20240611));
        for (int r = 0; r < 32; r++) mdl[r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1 idle after reset", {busy, done}, 0);
        compare_all("R1");

        // R9: test-port write to register 0 is dropped.
        tp_write(0, 32'hDEAD_BEEF);
        compare_all("R9 tp x0");

        // R4: 8-bit packed example, indices 1,3,2,0.
        preload();
        tp_write(8, 32'h0002_0301);
        old4 = mdl[4];
        run_op(4'b0101, 4, 1, 3, 8, 1'b0, "R4 example");
        tp_addr = 5'd3; #0.1;
        chk(tp_rdata == old4, "R4 x3 takes old x4", tp_rdata, old4);

        // R7 grouped against R8 running, same operands.
        preload();
        run_op(4'b0111, 3, 4, 12, 20, 1'b0, "R7 grouped");
        preload();
        run_op(4'b0101, 3, 4, 12, 20, 1'b0, "R8 running");

        // R3: each index width.
        preload();
        run_op(4'b1001, 4, 2, 5, 25, 1'b0, "R3 w16");
        preload();
        run_op(4'b1101, 3, 3, 6, 28, 1'b0, "R3 w32");
        preload();
        run_op(4'b0001, 5, 1, 10, 2, 1'b0, "R3 full");

        // R6: SUBVL of zero counts as one; R9 destination wrap over x0.
        preload();
        run_op(4'b0101, 5, 0, 1, 17, 1'b0, "R6 sub0");
        preload();
        run_op(4'b1111, 2, 3, 30, 11, 1'b0, "R9 wrap");

        // R11: VL of zero.
        run_op(4'b0101, 0, 3, 7, 9, 1'b0, "R11 vl0");

        // R2: codes without the move bit.
        try_ignored(4'b0000);
        try_ignored(4'b0110);

        // R10: restart and test write while busy.
        preload();
        run_op(4'b0111, 4, 3, 14, 3, 1'b1, "R10 poke");

        // Random mix (R5 and the rest).
        for (int t = 0; t < 30; t++) begin
            logic [3:0] f;
            f = 4'($urandom) | 4'b0001;
            preload();
            run_op(f, int'($urandom % 16), int'($urandom % 8), int'($urandom % 32),
                   int'($urandom % 32), 1'($urandom), $sformatf("R5 rand%0d", t));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule